// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a physical address into the DRAM chip-select row that holds it. Software programs one boundary register per row through a byte-wide write port. Each register holds an upper limit in 64 MiB units. The limits are cumulative, so the last active register holds the total installed memory. A row whose limit equals the limit of the row before it holds no memory. The decoder skips such a row.

A mode input selects single-channel operation, where all eight rows are active, or dual-channel operation, where only the lower four rows are active. For every address the block reports three things one clock later: the matching row index, a hit flag, and a vector that marks which rows are populated. An address that no active row covers clears the hit flag and reports row 0.

Top module: `rdb_decoder`

## Requirements
- R1: After reset every boundary register is zero, so `row_populated` is all zeros, `row_hit` is 0 and `row_sel` is 0.
- R2: A cycle with `cfg_wr_en` high stores bits 6:0 of `cfg_wr_data` as the boundary of row `cfg_wr_idx`. Bit 7 is reserved and is ignored.
- R3: A row is reported populated when it is active and its boundary differs from the boundary of the row below it. Row 0 is compared with zero.
- R4: With `dual_mode` = 0 all eight rows are active. With `dual_mode` = 1 only rows 0 to 3 are active, and rows 4 to 7 are reported unpopulated and are never selected.
- R5: The unit index is `addr[ADDR_W-1:26]`. The selected row is the lowest-numbered active, populated row whose boundary is greater than the unit index, and `row_hit` is 1.
- R6: Row i covers the addresses from the previous boundary times 64 MiB up to its own boundary times 64 MiB minus 1. The address at exactly a boundary belongs to the next populated row.
- R7: When no active populated row qualifies, including the case of an address at or above the last active boundary, `row_hit` is 0 and `row_sel` is 0.
- R8: The outputs are registered. They change only at a rising edge. At that edge they reflect the `addr` and `dual_mode` present at the edge and the boundary contents stored before it, so a write at the same edge takes effect one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dual_mode | input | 1 | 0 selects single-channel (all rows), 1 selects dual-channel (lower half) |
| cfg_wr_en | input | 1 | Boundary register write strobe |
| cfg_wr_idx | input | ROW_W | Row whose boundary is written |
| cfg_wr_data | input | REG_W | Write byte; bits 6:0 are the boundary, bit 7 is reserved |
| addr | input | ADDR_W | Physical address to decode |
| row_sel | output | ROW_W | Selected row index (0 on a miss) |
| row_hit | output | 1 | Address falls inside a populated active row |
| row_populated | output | NUM_ROWS | One bit per row, set when the row holds memory |

## Verification
The bench builds the decoder with a 34-bit address, so the unit index is 8 bits wide, one bit wider than a boundary. This brings unit indices above 127 within reach, together with the full top boundary of 127, so the zero-extended comparison is tested at both ends. Eight rows and dual-channel mode are used, so the bench can check rows that are active in one mode and inactive in the other.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
   typedef enum logic {
      CH_SINGLE = 1'b0,
      CH_DUAL   = 1'b1
   } ch_mode_e;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rdb_bound_regs.sv
module rdb_bound_regs #(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 7,
   parameter int REG_W    = 8,
   parameter int ROW_W    = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ROW_W-1:0]                   wr_idx,
   input  logic [REG_W-1:0]                   wr_data,
   output logic [NUM_ROWS-1:0][BND_W-1:0]     bnd
);
   for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bnd[i] <= '0;
         else if (wr_en && (wr_idx == ROW_W'(i)))
            bnd[i] <= wr_data[BND_W-1:0];
      end
   end

   if (REG_W > BND_W) begin : g_resv
      logic unused_resv;
      assign unused_resv = ^wr_data[REG_W-1:BND_W];
   end
endmodule

// File: rtl/rdb_row_match.sv
module rdb_row_match #(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 7,
   parameter int CMP_W    = 7
) (
   input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
   input  logic [CMP_W-1:0]               unit,
   input  rdb_pkg::ch_mode_e              mode,
   output logic [NUM_ROWS-1:0]            populated,
   output logic [NUM_ROWS-1:0]            match
);
   localparam int HALF = NUM_ROWS / 2;

   for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
      logic [BND_W-1:0] prev;
      logic             active;
      if (i == 0) begin : g_first
         assign prev = '0;
      end else begin : g_rest
         assign prev = bnd[i-1];
      end
      if (i < HALF) begin : g_lower
         assign active = 1'b1;
      end else begin : g_upper
         assign active = (mode == rdb_pkg::CH_SINGLE);
      end
      assign populated[i] = active && (bnd[i] != prev);
      assign match[i]     = populated[i] && (CMP_W'(bnd[i]) > unit);
   end
endmodule

// File: rtl/rdb_prio_enc.sv
module rdb_prio_enc #(
   parameter int N = 8,
   parameter int W = 3
) (
   input  logic [N-1:0] req,
   output logic [W-1:0] idx,
   output logic         any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/rdb_decoder.sv
module rdb_decoder #(
   parameter  int NUM_ROWS   = 8,
   parameter  int BND_W      = 7,
   parameter  int REG_W      = 8,
   parameter  int ADDR_W     = 32,
   parameter  int UNIT_SHIFT = 26,
   localparam int ROW_W      = $clog2(NUM_ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dual_mode,
   input  logic                cfg_wr_en,
   input  logic [ROW_W-1:0]    cfg_wr_idx,
   input  logic [REG_W-1:0]    cfg_wr_data,
   input  logic [ADDR_W-1:0]   addr,
   output logic [ROW_W-1:0]    row_sel,
   output logic                row_hit,
   output logic [NUM_ROWS-1:0] row_populated
);
   localparam int UNIT_W = ADDR_W - UNIT_SHIFT;
   localparam int CMP_W  = rdb_pkg::max_i(UNIT_W, BND_W);

   if (NUM_ROWS < 2 || (NUM_ROWS & (NUM_ROWS - 1)) != 0) begin : g_bad_rows
      $error("NUM_ROWS must be a power of two of at least 2");
   end
   if (UNIT_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("UNIT_SHIFT must be below ADDR_W");
   end
   if (BND_W > REG_W) begin : g_bad_bnd
      $error("BND_W must fit in REG_W");
   end

   logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
   logic [CMP_W-1:0]               unit;
   logic [NUM_ROWS-1:0]            pop_d, match_d;
   logic [ROW_W-1:0]               idx_d;
   logic                           any_d;
   rdb_pkg::ch_mode_e              mode;
   logic                           unused_low;

   assign mode       = rdb_pkg::ch_mode_e'(dual_mode);
   assign unit       = CMP_W'(addr[ADDR_W-1:UNIT_SHIFT]);
   assign unused_low = ^addr[UNIT_SHIFT-1:0];

   rdb_bound_regs #(
      .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .REG_W(REG_W), .ROW_W(ROW_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
      .wr_data(cfg_wr_data), .bnd(bnd)
   );

   rdb_row_match #(
      .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .CMP_W(CMP_W)
   ) i_match (
      .bnd(bnd), .unit(unit), .mode(mode),
      .populated(pop_d), .match(match_d)
   );

   rdb_prio_enc #(
      .N(NUM_ROWS), .W(ROW_W)
   ) i_prio (
      .req(match_d), .idx(idx_d), .any(any_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_sel       <= '0;
         row_hit       <= 1'b0;
         row_populated <= '0;
      end else begin
         row_sel       <= idx_d;
         row_hit       <= any_d;
         row_populated <= pop_d;
      end
   end
endmodule

// File: rtl/rdb_checker.sv
module rdb_checker #(
   parameter int NUM_ROWS = 8,
   parameter int ROW_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dual_mode,
   input logic [ROW_W-1:0]    row_sel,
   input logic                row_hit,
   input logic [NUM_ROWS-1:0] row_populated
);
   localparam int HALF = NUM_ROWS / 2;

   AST_MISS_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !row_hit |-> (row_sel == '0)); // R7

   AST_HIT_IN_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
      row_hit |-> row_populated[row_sel]); // R5

   AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (row_populated == '0) |-> !row_hit); // R3

   AST_DUAL_UPPER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dual_mode) |-> (row_populated[NUM_ROWS-1:HALF] == '0)); // R4

   AST_DUAL_LOWER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (row_hit && $past(dual_mode)) |-> ({1'b0, row_sel} < (ROW_W+1)'(HALF))); // R4
endmodule

bind rdb_decoder rdb_checker #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) i_rdb_checker (
   .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .row_sel(row_sel),
   .row_hit(row_hit), .row_populated(row_populated)
);

// File: tb/test_rdb_decoder.sv
`timescale 1ns/1ps
module test_rdb_decoder;
   localparam int NR = 8;
   localparam int AW = 34;
   localparam int RW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dual_mode = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [RW-1:0] cfg_wr_idx = '0;
   logic [7:0]    cfg_wr_data = '0;
   logic [AW-1:0] addr = '0;
   logic [RW-1:0] row_sel;
   logic          row_hit;
   logic [NR-1:0] row_populated;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   rdb_decoder #(.NUM_ROWS(NR), .ADDR_W(AW)) i_rdb_decoder (
      .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
      .addr(addr), .row_sel(row_sel), .row_hit(row_hit),
      .row_populated(row_populated)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [7:0] data);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_idx  = RW'(idx);
      cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
   endtask

   // present address for one edge, then check results after that edge
   task automatic dec(input string req, input logic [AW-1:0] a,
                      input logic ehit, input int erow);
      @(negedge clk);
      addr = a;
      @(posedge clk);
      #1;
      chk(req, $sformatf("hit @0x%0h", a), 32'(row_hit), 32'(ehit));
      chk(req, $sformatf("row @0x%0h", a), 32'(row_sel), 32'(erow));
   endtask

   function automatic logic [AW-1:0] u(input int unit, input int off);
      return (AW'(unit) << 26) + AW'(off);
   endfunction

   task automatic t_reset();
      #1;
      chk("R1", "populated", 32'(row_populated), 32'h0);
      chk("R1", "hit", 32'(row_hit), 32'h0);
      chk("R1", "row", 32'(row_sel), 32'h0);
      dec("R7", u(0, 0), 1'b0, 0); // nothing programmed: miss
      chk("R1", "populated after decode", 32'(row_populated), 32'h0);
   endtask

   // bounds 2,2,5,6(written 0x86),6,9,9,12 -> populated rows 0,2,3,5,7
   task automatic t_program();
      wr(0, 8'd2);  wr(1, 8'd2);  wr(2, 8'd5);  wr(3, 8'h86);
      wr(4, 8'd6);  wr(5, 8'd9);  wr(6, 8'd9);  wr(7, 8'd12);
      @(posedge clk); #1;
      chk("R3", "populated single", 32'(row_populated), 32'hAD);
      chk("R2", "reserved bit ignored", 32'(row_populated[4]), 32'h0);
      dec("R2", u(5, 0), 1'b1, 3);
   endtask

   task automatic t_single();
      dual_mode = 1'b0;
      dec("R5", u(0, 0), 1'b1, 0);
      dec("R6", u(1, 32'h3FF_FFFF), 1'b1, 0);
      dec("R6", u(2, 0), 1'b1, 2);            // row 1 empty, skipped
      dec("R6", u(5, 0) - 1, 1'b1, 2);
      dec("R5", u(5, 123), 1'b1, 3);
      dec("R6", u(6, 0), 1'b1, 5);            // row 4 empty, skipped
      dec("R5", u(8, 7), 1'b1, 5);
      dec("R6", u(9, 0), 1'b1, 7);            // row 6 empty, skipped
      dec("R6", u(12, 0) - 1, 1'b1, 7);
      dec("R7", u(12, 0), 1'b0, 0);           // exactly total size
      dec("R7", u(255, 5), 1'b0, 0);          // unit index wider than boundary
      dec("R5", u(3, 0), 1'b1, 2);            // recover after miss
   endtask

   task automatic t_dual();
      @(negedge clk);
      dual_mode = 1'b1;
      @(posedge clk); #1;
      chk("R4", "populated dual", 32'(row_populated), 32'h0D);
      dec("R4", u(5, 0), 1'b1, 3);
      dec("R4", u(6, 0), 1'b0, 0);            // upper rows inactive
      dec("R4", u(10, 0), 1'b0, 0);
      dec("R4", u(1, 0), 1'b1, 0);
      @(negedge clk);
      dual_mode = 1'b0;
      @(posedge clk); #1;
      chk("R4", "populated back to single", 32'(row_populated), 32'hAD);
   endtask

   task automatic t_latency();
      dec("R8", u(0, 0), 1'b1, 0);
      @(negedge clk);
      addr = u(10, 0);
      #1;
      chk("R8", "row held before edge", 32'(row_sel), 32'h0);
      @(posedge clk); #1;
      chk("R8", "row after edge", 32'(row_sel), 32'h7);
      // write and decode on the same edge: old boundary still applies
      @(negedge clk);
      addr        = u(15, 0);
      cfg_wr_en   = 1'b1;
      cfg_wr_idx  = 3'd7;
      cfg_wr_data = 8'd20;
      @(posedge clk); #1;
      chk("R8", "hit same edge as write", 32'(row_hit), 32'h0);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      @(posedge clk); #1;
      chk("R8", "hit after write", 32'(row_hit), 32'h1);
      chk("R8", "row after write", 32'(row_sel), 32'h7);
   endtask

   task automatic t_top_bound();
      wr(7, 8'hFF);                           // bound 127
      dec("R6", u(126, 0), 1'b1, 7);
      dec("R7", u(127, 0), 1'b0, 0);
      dec("R7", u(128, 0), 1'b0, 0);
      wr(7, 8'd9);                            // equals row 6 -> empty
      @(posedge clk); #1;
      chk("R3", "row 7 emptied", 32'(row_populated), 32'h2D);
      dec("R7", u(9, 0), 1'b0, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_single();
      t_dual();
      t_latency();
      t_top_bound();
      repeat (2) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule